// File: doc/BRIEF.md
# Port-input instruction bus sequencer

This block is a small bus master that carries out a single port-input instruction on a bus with an 8-bit data path and a 16-bit address. When it is started, it latches the program counter and runs three machine cycles back to back. The first is an opcode fetch at the program counter. The second is a memory read of the operand byte at the next address. The third is an I/O read of the port named by that operand. One bus clock is one T-state. The byte read from the port is loaded into an accumulator output, and a completion pulse follows.

The opcode fetch checks the fetched byte against the one opcode the sequencer knows. If the byte does not match, the sequence stops after the fetch and an illegal-opcode pulse is raised. The I/O read always adds one internal wait state between T2 and T3, without any request from the device. The count of added wait states is a parameter. Memory and port devices sit outside the block and return data on the shared input data bus while their strobes are low.

Top module: `io_in_seq`

## Requirements
- R1: While `rst_n` is low, all strobes (`mreq_n_o`, `iorq_n_o`, `rd_n_o`) are high, `done_o` and `illegal_o` are low and `acc_o` is 00h. This holds at once, even in the middle of a sequence.
- R2: Start is accepted only when the block is idle. Counting the first clock after the accepting edge as clock 1, the opcode fetch occupies clocks 1 to 3 with `addr_o` equal to the latched program counter. `mreq_n_o` and `rd_n_o` are low in clocks 2 and 3, and `iorq_n_o` stays high.
- R3: The operand read occupies clocks 4 to 6 with `addr_o` equal to the program counter plus one, modulo 2^16. `mreq_n_o` and `rd_n_o` are low in clocks 5 and 6.
- R4: The I/O read occupies clocks 7 to 10. `addr_o` is {00h, port} in all four. `iorq_n_o` and `rd_n_o` are low in clocks 8, 9 (the automatic wait) and 10, and `mreq_n_o` stays high.
- R5: The data bus is sampled at the end of clock 10 and appears on `acc_o` in clock 11. `done_o` is high for clock 11 only, with all strobes high and `addr_o` at 0000h.
- R6: When the byte fetched at the end of clock 3 is not DBh, `illegal_o` is high for clock 4 only. No operand or I/O cycle follows, the block is idle from clock 5, and `acc_o` keeps its value.
- R7: A start held high during a sequence, including the `done_o` clock, is ignored. In clock 12 the block is idle and `addr_o` is 0000h.
- R8: Port numbers 00h and FFh are both read correctly into the accumulator.
- R9: `mreq_n_o` and `iorq_n_o` are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to run the instruction; sampled only when idle |
| pc_i | input | 16 | Address of the opcode byte, latched on start |
| data_i | input | 8 | Input data bus from memory or port device |
| addr_o | output | 16 | Address bus |
| mreq_n_o | output | 1 | Active-low memory request strobe |
| iorq_n_o | output | 1 | Active-low I/O request strobe |
| rd_n_o | output | 1 | Active-low read strobe |
| acc_o | output | 8 | Accumulator holding the last byte read from a port |
| done_o | output | 1 | One-clock pulse when the port byte is loaded |
| illegal_o | output | 1 | One-clock pulse when the fetched opcode is not DBh |

## Verification
Two things can happen in the same clock. The completion clock, when the accumulator is loaded and `done_o` fires, can meet a start request that is still held high. The idle-only start rule must then win, so the completion does not fall straight into a new fetch. The bench provokes this by keeping start high from the accepting edge through the `done_o` clock. It judges the result by requiring an idle bus with address 0000h in clock 12, and a trace identical to one started by a single-clock pulse. A second collision happens when reset lands during the I/O wait state, while both I/O strobes are low. The bench checks that the strobes rise and the accumulator clears in that same clock.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OF1, S_OF2, S_OF3,
    S_MR1, S_MR2, S_MR3,
    S_IO1, S_IO2, S_IOW, S_IO3,
    S_FIN,
    S_BAD
  } seq_state_e;

endpackage

// File: rtl/io_seq_fsm.sv
module io_seq_fsm
  import io_seq_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  OPCODE   = 8'hDB,
  parameter int          NUM_WAIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output seq_state_e        state_o
);

  localparam int WCNT_W = (NUM_WAIT > 1) ? $clog2(NUM_WAIT) : 1;
  localparam logic [WCNT_W-1:0] WLAST = WCNT_W'(NUM_WAIT - 1);

  seq_state_e        state_q, state_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic              wcnt_en;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_OF1;
      S_OF1:  state_d = S_OF2;
      S_OF2:  state_d = S_OF3;
      S_OF3:  state_d = (data_i == DATA_W'(OPCODE)) ? S_MR1 : S_BAD;
      S_MR1:  state_d = S_MR2;
      S_MR2:  state_d = S_MR3;
      S_MR3:  state_d = S_IO1;
      S_IO1:  state_d = S_IO2;
      S_IO2:  state_d = S_IOW;
      S_IOW:  if (wcnt_q == WLAST) state_d = S_IO3;
      S_IO3:  state_d = S_FIN;
      S_FIN:  state_d = S_IDLE;
      S_BAD:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // wait-state counter
  always_comb begin
    wcnt_en = (state_q == S_IO2) || (state_q == S_IOW);
    wcnt_d  = (state_q == S_IOW) ? wcnt_q + WCNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (wcnt_en) begin
      wcnt_q <= wcnt_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/io_seq_dp.sv
module io_seq_dp
  import io_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] port_o,
  output logic [DATA_W-1:0] acc_o
);

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] port_q, acc_q;
  logic              pc_en, port_en, acc_en;

  always_comb begin
    pc_en   = (state_i == S_IDLE) && start_i;
    port_en = (state_i == S_MR3);
    acc_en  = (state_i == S_IO3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (pc_en) pc_q <= pc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_q <= '0;
    else if (port_en) port_q <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_en) acc_q <= data_i;
  end

  assign pc_o   = pc_q;
  assign port_o = port_q;
  assign acc_o  = acc_q;

endmodule

// File: rtl/io_seq_bus.sv
module io_seq_bus
  import io_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  seq_state_e        state_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] port_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mreq_n_o,
  output logic              iorq_n_o,
  output logic              rd_n_o
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] io_addr;
  assign io_addr = {{HI_W{1'b0}}, port_i};

  always_comb begin
    addr_o   = '0;
    mreq_n_o = 1'b1;
    iorq_n_o = 1'b1;
    rd_n_o   = 1'b1;
    unique case (state_i)
      S_OF1: addr_o = pc_i;
      S_OF2, S_OF3: begin
        addr_o   = pc_i;
        mreq_n_o = 1'b0;
        rd_n_o   = 1'b0;
      end
      S_MR1: addr_o = pc_i + ADDR_W'(1);
      S_MR2, S_MR3: begin
        addr_o   = pc_i + ADDR_W'(1);
        mreq_n_o = 1'b0;
        rd_n_o   = 1'b0;
      end
      S_IO1: addr_o = io_addr;
      S_IO2, S_IOW, S_IO3: begin
        addr_o   = io_addr;
        iorq_n_o = 1'b0;
        rd_n_o   = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/io_in_seq.sv
module io_in_seq
  import io_seq_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] OPCODE   = 8'hDB,
  parameter int         NUM_WAIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mreq_n_o,
  output logic              iorq_n_o,
  output logic              rd_n_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              done_o,
  output logic              illegal_o
);

  seq_state_e        state;
  logic [ADDR_W-1:0] pc_l;
  logic [DATA_W-1:0] port_l;

  io_seq_fsm #(
    .DATA_W(DATA_W), .OPCODE(OPCODE), .NUM_WAIT(NUM_WAIT)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .data_i(data_i), .state_o(state)
  );

  io_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .state_i(state), .start_i(start_i),
    .pc_i(pc_i), .data_i(data_i),
    .pc_o(pc_l), .port_o(port_l), .acc_o(acc_o)
  );

  io_seq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
    .state_i(state), .pc_i(pc_l), .port_i(port_l),
    .addr_o(addr_o), .mreq_n_o(mreq_n_o),
    .iorq_n_o(iorq_n_o), .rd_n_o(rd_n_o)
  );

  assign done_o    = (state == S_FIN);
  assign illegal_o = (state == S_BAD);

endmodule

// File: rtl/io_in_seq_chk.sv
module io_in_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_o,
  input logic              mreq_n_o,
  input logic              iorq_n_o,
  input logic              rd_n_o,
  input logic [DATA_W-1:0] acc_o,
  input logic              done_o,
  input logic              illegal_o
);

  localparam int HI_W = ADDR_W - DATA_W;

  p_no_dual_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mreq_n_o && !iorq_n_o));

  p_mem_read_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mreq_n_o |-> !rd_n_o);

  p_io_read_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !iorq_n_o |-> (!rd_n_o && addr_o[ADDR_W-1:DATA_W] == HI_W'(0)));

  p_io_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iorq_n_o) |=> !iorq_n_o ##1 !iorq_n_o);

  p_done_after_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (iorq_n_o && mreq_n_o && rd_n_o && $past(!iorq_n_o)));

  p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || $stable(acc_o)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_illegal_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> (!illegal_o && mreq_n_o && iorq_n_o));

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && illegal_o));

endmodule

bind io_in_seq io_in_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_o(addr_o), .mreq_n_o(mreq_n_o),
  .iorq_n_o(iorq_n_o), .rd_n_o(rd_n_o), .acc_o(acc_o),
  .done_o(done_o), .illegal_o(illegal_o)
);

// File: tb/io_in_seq_tb_top.sv
module io_in_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {pc, opcode, port}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h2065, 8'hDB, 8'h84},
    {16'h1000, 8'hDB, 8'h00},
    {16'h3000, 8'hDB, 8'hFF},
    {16'h4000, 8'h3E, 8'h55},
    {16'hFFFF, 8'hDB, 8'h12},
    {16'h0100, 8'hDB, 8'hA7}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] pc;
  logic [7:0]  data;
  logic [15:0] addr;
  logic        mreq_n, iorq_n, rd_n, done, illegal;
  logic [7:0]  acc;

  logic [15:0] cur_pc;
  logic [7:0]  cur_op, cur_port, exp_acc;
  int          n_chk = 0;
  int          n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory and port model
  always_comb begin
    if (!mreq_n && !rd_n)
      data = (addr == cur_pc) ? cur_op :
             (addr == cur_pc + 16'd1) ? cur_port : 8'h00;
    else if (!iorq_n && !rd_n)
      data = addr[7:0] ^ 8'h5A;
    else
      data = 8'hFF;
  end

  io_in_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pc_i(pc), .data_i(data),
    .addr_o(addr), .mreq_n_o(mreq_n), .iorq_n_o(iorq_n), .rd_n_o(rd_n),
    .acc_o(acc), .done_o(done), .illegal_o(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_bus(input string req, input logic [15:0] ea,
                         input logic em, input logic ei, input logic er,
                         input logic ed, input logic el);
    chk(addr == ea, req, addr, ea);
    chk({mreq_n, iorq_n, rd_n} == {em, ei, er}, req,
        {mreq_n, iorq_n, rd_n}, {em, ei, er});
    chk({done, illegal} == {ed, el}, req, {done, illegal}, {ed, el});
    chk(!(!mreq_n && !iorq_n), "R9", {mreq_n, iorq_n}, 2'b11);
  endtask

  task automatic run_seq(input logic [15:0] vpc, input logic [7:0] vop,
                         input logic [7:0] vport, input bit hold);
    bit legal = (vop == 8'hDB);
    int last = legal ? 12 : 5;
    logic [15:0] io_a = {8'h00, vport};
    cur_pc = vpc; cur_op = vop; cur_port = vport;
    @(negedge clk);
    pc = vpc; start = 1'b1;
    for (int c = 1; c <= last; c++) begin
      @(negedge clk);
      if (c == 1 && !hold) start = 1'b0;
      case (c)
        1:      chk_bus("R2", vpc, 1, 1, 1, 0, 0);
        2, 3:   chk_bus("R2", vpc, 0, 1, 0, 0, 0);
        4:      if (legal) chk_bus("R3", vpc + 16'd1, 1, 1, 1, 0, 0);
                else       chk_bus("R6", 16'h0000, 1, 1, 1, 0, 1);
        5:      if (legal) chk_bus("R3", vpc + 16'd1, 0, 1, 0, 0, 0);
                else begin
                  chk_bus("R6", 16'h0000, 1, 1, 1, 0, 0);
                  chk(acc == exp_acc, "R6", acc, exp_acc);
                end
        6:      chk_bus("R3", vpc + 16'd1, 0, 1, 0, 0, 0);
        7:      chk_bus("R4", io_a, 1, 1, 1, 0, 0);
        8, 9, 10: chk_bus("R4", io_a, 1, 0, 0, 0, 0);
        11: begin
          exp_acc = vport ^ 8'h5A;
          chk_bus("R5", 16'h0000, 1, 1, 1, 1, 0);
          if (vport == 8'h00 || vport == 8'hFF)
            chk(acc == exp_acc, "R8", acc, exp_acc);
          else
            chk(acc == exp_acc, "R5", acc, exp_acc);
        end
        12: chk_bus(hold ? "R7" : "R5", 16'h0000, 1, 1, 1, 0, 0);
        default: ;
      endcase
    end
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; pc = '0;
    cur_pc = 16'hDEAD; cur_op = 8'h00; cur_port = 8'h00; exp_acc = 8'h00;
    repeat (3) @(negedge clk);
    chk_bus("R1", 16'h0000, 1, 1, 1, 0, 0);
    chk(acc == 8'h00, "R1", acc, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++)
      run_seq(VEC[i][31:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

    // start held high through the completion clock
    run_seq(16'h5A00, 8'hDB, 8'h3C, 1'b1);
    @(negedge clk);
    chk_bus("R7", 16'h0000, 1, 1, 1, 0, 0);

    // reset during the I/O wait state
    cur_pc = 16'h7000; cur_op = 8'hDB; cur_port = 8'h21;
    @(negedge clk);
    pc = 16'h7000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    chk(!iorq_n && !rd_n, "R4", {iorq_n, rd_n}, 2'b00);
    rst_n = 1'b0;
    #1;
    chk_bus("R1", 16'h0000, 1, 1, 1, 0, 0);
    chk(acc == 8'h00, "R1", acc, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_bus("R1", 16'h0000, 1, 1, 1, 0, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule